// File: doc/BRIEF.md
# Synthesizer Divider Command Controller

This block sits between a byte-wide register bus and the divider chain of a frequency synthesizer. It keeps two copies of the divider configuration. The first is a pair of register images that software reads and writes. The second is the live divider state that drives the feedback divider M (10 bits), the post-dividers NA (3 bits) and NB (1 bit), and the pre-divider P (1 bit). A write-only command address moves state between the two copies. It can also step the live feedback divider up or down by one, for quick frequency margining, without touching the register images.

A mode input chooses which side controls the configuration. Under parallel control the live dividers follow the hardware divider pins, and the register images mirror them so they can be read back. The bus cannot change anything in this mode. Under serial control the pins are ignored. Register writes only stage a configuration, and a load command applies it. The block checks no command for range or validity, so stepping can push M outside a usable range.

Top module: `synth_div_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the live dividers and both register images to zero.
- R2: Under serial control, address 0x00 reads back the last byte written to it, which holds M bits 7..0 of the register image.
- R3: Address 0x01 reads as {M[9:8] in bits 7:6, NA in bits 5:3, NB in bit 2, P in bit 1, lock input in bit 0}. Bit 0 always shows the current lock input, and a written bit 0 is discarded.
- R4: A write to address 0xF0 decodes only data bits 3:0. The code 0x1 increments M, 0x2 decrements M, 0x4 loads the register images into the live dividers, and 0x8 copies the live dividers into the images. Every other code does nothing.
- R5: Increment and decrement change only the live M. The change appears one clock after the write. 1023 steps up to 0, 0 steps down to 1023, and the register images stay as they were.
- R6: Under serial control, the live dividers change only through a load, increment or decrement command. Register writes alone leave them unchanged.
- R7: The copy command makes the register images equal to the live dividers one clock after the write.
- R8: Under parallel control, the live dividers and the register images both take the pin values at every clock edge. Reads of 0x00/0x01 therefore return the pin configuration sampled at the previous edge.
- R9: Under parallel control, register writes and all command writes, including the copy command, have no effect.
- R10: On a change from parallel to serial control, the live dividers and the register images keep the values last taken from the pins.
- R11: A read of 0xF0 or of any address other than 0x00/0x01 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel | input | 1 | 1 = serial (bus) control, 0 = parallel (pin) control |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_m | input | 10 | Parallel feedback divider pins |
| pin_na | input | 3 | Parallel NA post-divider pins |
| pin_nb | input | 1 | Parallel NB post-divider pin |
| pin_p | input | 1 | Parallel pre-divider pin |
| lock_in | input | 1 | PLL lock status |
| div_m | output | 10 | Live feedback divider |
| div_na | output | 3 | Live NA post-divider |
| div_nb | output | 1 | Live NB post-divider |
| div_p | output | 1 | Live pre-divider |

## Verification
The bench uses the default parameters: a 10-bit M, a 3-bit NA, register addresses 0x00/0x01 and command address 0xF0. With a 10-bit M, both wrap points (1023 up to 0 and 0 down to 1023) can be reached with two register writes and a load. The high register packs exactly into eight bits, so every field position of address 0x01, including the lock bit, can be checked with a single read. The bench switches the mode input in both directions in the middle of the run, so the hand-over of state between the pins, the live dividers and the images is exercised.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int M_W     = 10;
    localparam int NA_W    = 3;
    localparam int DATA_W  = 8;
    localparam int M_HI_W  = M_W - DATA_W;
    // bit positions inside the high configuration register
    localparam int LOCK_BIT = 0;
    localparam int P_BIT    = 1;
    localparam int NB_BIT   = 2;
    localparam int NA_LSB   = 3;
    localparam int MHI_LSB  = NA_LSB + NA_W;

    localparam logic [3:0] CODE_INC  = 4'h1;
    localparam logic [3:0] CODE_DEC  = 4'h2;
    localparam logic [3:0] CODE_LOAD = 4'h4;
    localparam logic [3:0] CODE_GET  = 4'h8;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [NA_W-1:0] na;
        logic            nb;
        logic            p;
    } div_cfg_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INC,
        OP_DEC,
        OP_LOAD,
        OP_GET
    } op_e;
endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 'h00,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 'h01,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'hF0
) (
    input  logic              ser_sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        code,
    output op_e               op,
    output logic              wr_lo,
    output logic              wr_hi
);
    logic bus_live;

    always_comb begin
        bus_live = wr && ser_sel;
        wr_lo    = bus_live && (addr == LO_ADDR);
        wr_hi    = bus_live && (addr == HI_ADDR);
        op       = OP_NONE;
        if (bus_live && (addr == CMD_ADDR)) begin
            case (code)
                CODE_INC:  op = OP_INC;
                CODE_DEC:  op = OP_DEC;
                CODE_LOAD: op = OP_LOAD;
                CODE_GET:  op = OP_GET;
                default:   op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdc_div_state.sv
module sdc_div_state
    import sdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_sel,
    input  div_cfg_t pin_cfg,
    input  div_cfg_t img_cfg,
    input  op_e      op,
    output div_cfg_t live
);
    typedef struct packed {
        div_cfg_t cfg;
    } live_st_t;

    live_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ser_sel) begin
            st_d.cfg = pin_cfg;
        end else begin
            case (op)
                OP_INC:  st_d.cfg.m = st_q.cfg.m + 1'b1;
                OP_DEC:  st_d.cfg.m = st_q.cfg.m - 1'b1;
                OP_LOAD: st_d.cfg   = img_cfg;
                default: st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign live = st_q.cfg;

    // R5
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && op == OP_INC) |=> (live.m == $past(live.m) + 1'b1));
    // R5
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && op == OP_DEC) |=> (live.m == $past(live.m) - 1'b1));
    // R8
    pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_sel |=> (live == $past(pin_cfg)));
    // R6
    serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && (op == OP_NONE || op == OP_GET)) |=> $stable(live));
endmodule

// File: rtl/sdc_reg_image.sv
module sdc_reg_image
    import sdc_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] HI_ADDR = 'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  op_e               op,
    input  div_cfg_t          pin_cfg,
    input  div_cfg_t          live,
    input  logic              lock_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output div_cfg_t          img_cfg
);
    typedef struct packed {
        div_cfg_t img;
    } img_st_t;

    img_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ser_sel) begin
            st_d.img = pin_cfg;
        end else if (op == OP_GET) begin
            st_d.img = live;
        end else begin
            if (wr_lo) st_d.img.m[DATA_W-1:0] = wdata;
            if (wr_hi) begin
                st_d.img.m[M_W-1:DATA_W] = wdata[MHI_LSB +: M_HI_W];
                st_d.img.na              = wdata[NA_LSB +: NA_W];
                st_d.img.nb              = wdata[NB_BIT];
                st_d.img.p               = wdata[P_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_addr == LO_ADDR) begin
            rdata = st_q.img.m[DATA_W-1:0];
        end else if (rd_addr == HI_ADDR) begin
            rdata[MHI_LSB +: M_HI_W] = st_q.img.m[M_W-1:DATA_W];
            rdata[NA_LSB +: NA_W]    = st_q.img.na;
            rdata[NB_BIT]            = st_q.img.nb;
            rdata[P_BIT]             = st_q.img.p;
            rdata[LOCK_BIT]          = lock_in;
        end
    end

    assign img_cfg = st_q.img;

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != LO_ADDR && rd_addr != HI_ADDR) |-> (rdata == '0));
    // R7
    get_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && op == OP_GET) |=> (img_cfg == $past(live)));
    // R5
    step_keeps_img_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && (op == OP_INC || op == OP_DEC)) |=> $stable(img_cfg));
    // R3
    lock_view_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == HI_ADDR) |-> (rdata[LOCK_BIT] == lock_in));
endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
    import sdc_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 'h00,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 'h01,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [M_W-1:0]    pin_m,
    input  logic [NA_W-1:0]   pin_na,
    input  logic              pin_nb,
    input  logic              pin_p,
    input  logic              lock_in,
    output logic [M_W-1:0]    div_m,
    output logic [NA_W-1:0]   div_na,
    output logic              div_nb,
    output logic              div_p
);
    div_cfg_t pin_cfg, img_cfg, live;
    op_e      op;
    logic     wr_lo, wr_hi;

    assign pin_cfg = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};

    sdc_cmd_decode #(
        .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .ser_sel(ser_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .code   (bus_wdata[3:0]),
        .op     (op),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi)
    );

    sdc_div_state u_live (
        .clk    (clk),
        .rst    (rst),
        .ser_sel(ser_sel),
        .pin_cfg(pin_cfg),
        .img_cfg(img_cfg),
        .op     (op),
        .live   (live)
    );

    sdc_reg_image #(
        .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_img (
        .clk    (clk),
        .rst    (rst),
        .ser_sel(ser_sel),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (bus_wdata),
        .op     (op),
        .pin_cfg(pin_cfg),
        .live   (live),
        .lock_in(lock_in),
        .rd_addr(bus_addr),
        .rdata  (bus_rdata),
        .img_cfg(img_cfg)
    );

    assign div_m  = live.m;
    assign div_na = live.na;
    assign div_nb = live.nb;
    assign div_p  = live.p;

    // R4
    unlisted_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && bus_wr && bus_addr == CMD_ADDR &&
         bus_wdata[3:0] != CODE_INC && bus_wdata[3:0] != CODE_DEC &&
         bus_wdata[3:0] != CODE_LOAD && bus_wdata[3:0] != CODE_GET)
        |=> ($stable(div_m) && $stable(div_na) && $stable(div_nb) && $stable(div_p)));
endmodule

// File: tb/synth_div_ctrl_tb_top.sv
module synth_div_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_sel = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic [9:0] pin_m = 10'h000;
    logic [2:0] pin_na = 3'h0;
    logic       pin_nb = 1'b0;
    logic       pin_p = 1'b0;
    logic       lock_in = 1'b0;
    logic [9:0] div_m;
    logic [2:0] div_na;
    logic       div_nb, div_p;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int m_live = 0, na_live = 0, nb_live = 0, p_live = 0;
    int m_img = 0, na_img = 0, nb_img = 0, p_img = 0;

    always #10 clk = ~clk;

    synth_div_ctrl dut_i (
        .clk(clk), .rst(rst), .ser_sel(ser_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata),
        .pin_m(pin_m), .pin_na(pin_na), .pin_nb(pin_nb), .pin_p(pin_p),
        .lock_in(lock_in),
        .div_m(div_m), .div_na(div_na), .div_nb(div_nb), .div_p(div_p)
    );

    task automatic step(input string req);
        int nm, nna, nnb, np, im, ina, inb, ip, code, exp_rd;
        nm = m_live; nna = na_live; nnb = nb_live; np = p_live;
        im = m_img;  ina = na_img;  inb = nb_img;  ip = p_img;
        if (rst) begin
            nm = 0; nna = 0; nnb = 0; np = 0; im = 0; ina = 0; inb = 0; ip = 0;
        end else if (!ser_sel) begin
            nm = pin_m; nna = pin_na; nnb = pin_nb; np = pin_p;
            im = pin_m; ina = pin_na; inb = pin_nb; ip = pin_p;
        end else if (bus_wr) begin
            if (bus_addr == 8'h00) im = (m_img & 10'h300) | bus_wdata;
            else if (bus_addr == 8'h01) begin
                im  = (m_img & 8'hFF) | ((bus_wdata >> 6) << 8);
                ina = (bus_wdata >> 3) & 7;
                inb = (bus_wdata >> 2) & 1;
                ip  = (bus_wdata >> 1) & 1;
            end else if (bus_addr == 8'hF0) begin
                code = bus_wdata & 15;
                if (code == 1) nm = (m_live + 1) % 1024;
                else if (code == 2) nm = (m_live + 1023) % 1024;
                else if (code == 4) begin
                    nm = m_img; nna = na_img; nnb = nb_img; np = p_img;
                end else if (code == 8) begin
                    im = m_live; ina = na_live; inb = nb_live; ip = p_live;
                end
            end
        end
        @(posedge clk);
        m_live = nm; na_live = nna; nb_live = nnb; p_live = np;
        m_img = im;  na_img = ina;  nb_img = inb;  p_img = ip;
        @(negedge clk);
        checks++;
        if (div_m !== 10'(m_live) || div_na !== 3'(na_live) ||
            div_nb !== 1'(nb_live) || div_p !== 1'(p_live)) begin
            fails++;
            $display("FAIL %s dividers: actual m=%0d na=%0d nb=%0d p=%0d expected m=%0d na=%0d nb=%0d p=%0d",
                     req, div_m, div_na, div_nb, div_p, m_live, na_live, nb_live, p_live);
        end
        if (bus_addr == 8'h00) exp_rd = m_img & 8'hFF;
        else if (bus_addr == 8'h01)
            exp_rd = ((m_img >> 8) << 6) | (na_img << 3) | (nb_img << 2) | (p_img << 1) | int'(lock_in);
        else exp_rd = 0;
        checks++;
        if (bus_rdata !== 8'(exp_rd)) begin
            fails++;
            $display("FAIL %s read 0x%02h: actual 0x%02h expected 0x%02h",
                     req, bus_addr, bus_rdata, exp_rd[7:0]);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string req);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(req);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        bus_addr = a; bus_wr = 1'b0;
        step(req);
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state, pins busy so a leak would show
        pin_m = 10'h3A5; pin_na = 3'h6; ser_sel = 1'b0;
        step("R1"); step("R1");
        ser_sel = 1'b1;
        step("R1");
        rst = 1'b0;
        bus_read(8'h00, "R1");
        bus_read(8'h01, "R1");

        // R2 / R6: stage low byte, dividers untouched
        bus_write(8'h00, 8'h5A, "R6");
        bus_read(8'h00, "R2");
        // R3: high register layout, bit0 write discarded
        bus_write(8'h01, 8'hAF, "R3");
        lock_in = 1'b0; bus_read(8'h01, "R3");
        lock_in = 1'b1; bus_read(8'h01, "R3");
        // R4 load
        bus_write(8'hF0, 8'h04, "R4");
        // R4/R5 increment with upper nibble set
        bus_write(8'hF0, 8'hF1, "R5");
        bus_read(8'h00, "R5");
        bus_write(8'hF0, 8'h02, "R5");
        bus_write(8'hF0, 8'h32, "R5");
        // R4 unlisted codes
        bus_write(8'hF0, 8'h03, "R4");
        bus_write(8'hF0, 8'h0C, "R4");
        bus_write(8'hF0, 8'h00, "R4");
        bus_write(8'hF0, 8'h4F, "R4");
        // R5 wrap points
        bus_write(8'h00, 8'hFF, "R6");
        bus_write(8'h01, 8'hC0, "R6");
        bus_write(8'hF0, 8'h04, "R4");
        bus_write(8'hF0, 8'h01, "R5");
        bus_write(8'hF0, 8'h02, "R5");
        bus_write(8'hF0, 8'h01, "R5");
        bus_write(8'hF0, 8'h01, "R5");
        // R7 get
        bus_write(8'hF0, 8'h08, "R7");
        bus_read(8'h00, "R7");
        bus_read(8'h01, "R7");
        // R11 unmapped reads
        bus_read(8'hF0, "R11");
        bus_read(8'h02, "R11");
        bus_read(8'h7F, "R11");

        // R8 parallel control
        ser_sel = 1'b0; pin_m = 10'h2C3; pin_na = 3'h5; pin_nb = 1'b1; pin_p = 1'b0;
        bus_read(8'h00, "R8");
        bus_read(8'h01, "R8");
        pin_m = 10'h011; pin_na = 3'h2; pin_nb = 1'b0; pin_p = 1'b1;
        bus_read(8'h01, "R8");
        // R9 writes and commands ignored
        bus_write(8'h00, 8'hEE, "R9");
        bus_write(8'h01, 8'h3E, "R9");
        bus_write(8'hF0, 8'h01, "R9");
        bus_write(8'hF0, 8'h08, "R9");
        bus_read(8'h00, "R9");
        // R10 back to serial, state kept while pins move
        ser_sel = 1'b1; pin_m = 10'h3FF; pin_na = 3'h7; pin_nb = 1'b1; pin_p = 1'b0;
        bus_read(8'h00, "R10");
        bus_read(8'h01, "R10");
        bus_write(8'hF0, 8'h02, "R10");
        bus_write(8'hF0, 8'h04, "R10");
        // R1 reset again mid-run
        rst = 1'b1; step("R1");
        rst = 1'b0; bus_read(8'h01, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule